// File: doc/BRIEF.md
# Page-Bounded Flash Program Splitter

This block accepts one program request (a start address, a byte count and a stream of bytes) and turns it into a series of program operations for a serial NOR flash. No operation crosses a page boundary. The first piece ends at the next page boundary, or at the end of the request if that comes first. Every later piece is one whole page, except the last, which holds whatever bytes are left.

Each piece runs its own handshake with the flash. First a write-enable command goes out, followed by a poll until the write-enable latch bit reads set. Then the program command goes out, carrying the piece's address and length, and its bytes are passed through from the input stream. Last comes a poll until the write-in-progress bit reads clear. Two ports carry this traffic: a command port to a serial-line sequencer and a status-poller port. The block signals completion with a one-cycle `done` pulse. A failure reported on either port stops the whole request and produces a one-cycle `err` pulse instead.

Top module: `flash_prog_splitter`

## Requirements
- R1: The first program command's length is min(PAGE_BYTES − (start mod PAGE_BYTES), total length). A page-aligned start therefore gets a full page, or the whole request if it is shorter than a page.
- R2: Each program command after the first starts where the previous one ended. Its length is PAGE_BYTES, or the remaining byte count if that is smaller. Commands stop once the address reaches start + length.
- R3: Before every program command the block issues a write-enable command (cmd_op = 1). It then issues a poll with mask 0x02 and match 0x02 (status bit 1 = write-enable latch) and waits for that poll to complete.
- R4: A program command has cmd_op = 2, cmd_quad = 1 (address and data on four lines) and cmd_dummy = 0.
- R5: After the program command completes, the block issues a poll with mask 0x01 and match 0x00 (status bit 0 = write in progress). The next piece starts, or done is raised, only after that poll completes.
- R6: After each program command is accepted, exactly cmd_len stream bytes are passed from s_data to wr_data, in arrival order.
- R7: An error flag on any command or poll completion aborts the request. err pulses for one cycle, no further command or poll is issued, and req_ready returns high.
- R8: A zero-length request raises done in the cycle after it is accepted. No command or poll is issued.
- R9: During and right after reset, req_ready is 1 and cmd_valid, poll_valid, wr_valid, done and err are 0.
- R10: On success, done pulses for one cycle after the last write-in-progress poll completes. done and err are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Program request valid |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Total byte count |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Input byte taken |
| s_data | input | 8 | Input byte |
| cmd_valid | output | 1 | Command request to sequencer |
| cmd_ready | input | 1 | Sequencer takes command |
| cmd_op | output | 2 | 1 = write enable, 2 = program |
| cmd_addr | output | ADDR_W | Program address |
| cmd_len | output | LEN_W | Program byte count |
| cmd_quad | output | 1 | Four-line address and data |
| cmd_dummy | output | 4 | Dummy cycle count |
| cmd_done | input | 1 | Command (and its data) finished |
| cmd_err | input | 1 | Command failed, valid with cmd_done |
| wr_valid | output | 1 | Program byte valid to sequencer |
| wr_ready | input | 1 | Sequencer takes byte |
| wr_data | output | 8 | Program byte |
| poll_valid | output | 1 | Poll request |
| poll_ready | input | 1 | Poller takes request |
| poll_mask | output | 8 | Status bits compared |
| poll_match | output | 8 | Required value of masked bits |
| poll_done | input | 1 | Poll finished |
| poll_err | input | 1 | Poll failed, valid with poll_done |
| done | output | 1 | Request completed |
| err | output | 1 | Request aborted |

## Verification
The bench uses several request shapes, and each one separates a different fault in the length arithmetic:
- a page-aligned full page, which shows whether an aligned start gets a whole first piece;
- a short tail crossing one boundary, which tests both the cut at the boundary and the remainder after it;
- a small request inside one page, which tests the cap at the total size;
- a run over four pages with odd ends, which tests the advance of the address and the final remainder.

A zero-length request shows that the block completes without sending anything. Errors are injected at the latch poll, at the program completion and at the busy poll, which shows that each stage aborts and that no later traffic follows.

// File: rtl/flash_split_pkg.sv
package flash_split_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WEN_REQ,
    ST_WEN_WAIT,
    ST_WEL_REQ,
    ST_WEL_WAIT,
    ST_PRG_REQ,
    ST_PRG_DATA,
    ST_PRG_WAIT,
    ST_WIP_REQ,
    ST_WIP_WAIT
  } split_state_e;

  localparam logic [1:0] OP_WREN = 2'd1;
  localparam logic [1:0] OP_PROG = 2'd2;

  // status register bit positions decoded by the poller
  localparam int unsigned STAT_BIT_WIP = 0;
  localparam int unsigned STAT_BIT_WEL = 1;

endpackage

// File: rtl/fps_chunk.sv
module fps_chunk #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [LEN_W-1:0]  remaining,
  output logic [LEN_W-1:0]  chunk,
  output logic              last
);
  localparam int OFF_W = $clog2(PAGE_BYTES);

  logic [LEN_W:0] room;

  // bytes left before the next page boundary
  assign room  = (LEN_W+1)'(PAGE_BYTES) - {{(LEN_W+1-OFF_W){1'b0}}, cur_addr[OFF_W-1:0]};
  assign chunk = ({1'b0, remaining} < room) ? remaining : room[LEN_W-1:0];
  assign last  = (remaining == chunk);

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import flash_split_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_quad,
  output logic [3:0]        cmd_dummy,
  input  logic              cmd_done,
  input  logic              cmd_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [7:0]        wr_data,
  output logic              poll_valid,
  input  logic              poll_ready,
  output logic [7:0]        poll_mask,
  output logic [7:0]        poll_match,
  input  logic              poll_done,
  input  logic              poll_err,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remaining,
  input  logic [LEN_W-1:0]  chunk,
  input  logic              last
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam logic [7:0] WEL_MASK = 8'(1 << STAT_BIT_WEL);
  localparam logic [7:0] WIP_MASK = 8'(1 << STAT_BIT_WIP);

  split_state_e      st_q, st_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LEN_W-1:0]  rem_q, rem_n;
  logic [LEN_W-1:0]  beats_q, beats_n;
  logic              done_q, done_n, err_q, err_n;
  logic              ctx_en, beat_en, beat_fire;

  assign beat_fire = wr_valid && wr_ready;

  // next-state process
  always_comb begin
    st_n    = st_q;
    addr_n  = addr_q;
    rem_n   = rem_q;
    beats_n = beats_q;
    done_n  = 1'b0;
    err_n   = 1'b0;
    ctx_en  = 1'b0;
    beat_en = 1'b0;
    case (st_q)
      ST_IDLE: if (req_valid) begin
        ctx_en = 1'b1;
        addr_n = req_addr;
        rem_n  = req_len;
        if (req_len == '0) done_n = 1'b1;
        else               st_n   = ST_WEN_REQ;
      end
      ST_WEN_REQ:  if (cmd_ready) st_n = ST_WEN_WAIT;
      ST_WEN_WAIT: if (cmd_done) begin
        if (cmd_err) begin err_n = 1'b1; st_n = ST_IDLE; end
        else st_n = ST_WEL_REQ;
      end
      ST_WEL_REQ:  if (poll_ready) st_n = ST_WEL_WAIT;
      ST_WEL_WAIT: if (poll_done) begin
        if (poll_err) begin err_n = 1'b1; st_n = ST_IDLE; end
        else st_n = ST_PRG_REQ;
      end
      ST_PRG_REQ: if (cmd_ready) begin
        beat_en = 1'b1;
        beats_n = chunk;
        st_n    = ST_PRG_DATA;
      end
      ST_PRG_DATA: if (beat_fire) begin
        beat_en = 1'b1;
        beats_n = beats_q - 1'b1;
        if (beats_q == LEN_W'(1)) st_n = ST_PRG_WAIT;
      end
      ST_PRG_WAIT: if (cmd_done) begin
        if (cmd_err) begin err_n = 1'b1; st_n = ST_IDLE; end
        else st_n = ST_WIP_REQ;
      end
      ST_WIP_REQ:  if (poll_ready) st_n = ST_WIP_WAIT;
      ST_WIP_WAIT: if (poll_done) begin
        if (poll_err) begin
          err_n = 1'b1;
          st_n  = ST_IDLE;
        end else begin
          ctx_en = 1'b1;
          addr_n = addr_q + ADDR_W'(chunk);
          rem_n  = rem_q - chunk;
          if (last) begin done_n = 1'b1; st_n = ST_IDLE; end
          else st_n = ST_WEN_REQ;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      beats_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      err_q  <= err_n;
      if (ctx_en) begin
        addr_q <= addr_n;
        rem_q  <= rem_n;
      end
      if (beat_en) beats_q <= beats_n;
    end
  end

  assign cur_addr   = addr_q;
  assign remaining  = rem_q;
  assign req_ready  = (st_q == ST_IDLE);
  assign cmd_valid  = (st_q == ST_WEN_REQ) || (st_q == ST_PRG_REQ);
  assign cmd_op     = (st_q == ST_PRG_REQ) ? OP_PROG : OP_WREN;
  assign cmd_addr   = addr_q;
  assign cmd_len    = (st_q == ST_PRG_REQ) ? chunk : '0;
  assign cmd_quad   = (st_q == ST_PRG_REQ);
  assign cmd_dummy  = 4'd0;
  assign poll_valid = (st_q == ST_WEL_REQ) || (st_q == ST_WIP_REQ);
  assign poll_mask  = (st_q == ST_WEL_REQ) ? WEL_MASK : WIP_MASK;
  assign poll_match = (st_q == ST_WEL_REQ) ? WEL_MASK : 8'h00;
  assign wr_valid   = (st_q == ST_PRG_DATA) && s_valid;
  assign s_ready    = (st_q == ST_PRG_DATA) && wr_ready;
  assign wr_data    = s_data;
  assign done       = done_q;
  assign err        = err_q;

  // R1 / R2: a program command never runs past its page and is never empty
  a_r1_within_page: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PROG) |->
      (cmd_len != '0) &&
      ((int'(cmd_addr[OFF_W-1:0]) + int'(cmd_len)) <= PAGE_BYTES));

  // R2: a pending command keeps its fields until taken
  a_r2_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_addr)));

  // R7: after an abort the block is idle again
  a_r7_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> req_ready);

  // R10: completion and abort are exclusive
  a_r10_done_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);

  // R8 / R9: an idle block drives no traffic
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!cmd_valid && !poll_valid && !wr_valid));

endmodule

// File: rtl/flash_prog_splitter.sv
module flash_prog_splitter #(
  parameter int ADDR_W     = 24,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [1:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_quad,
  output logic [3:0]        cmd_dummy,
  input  logic              cmd_done,
  input  logic              cmd_err,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [7:0]        wr_data,
  output logic              poll_valid,
  input  logic              poll_ready,
  output logic [7:0]        poll_mask,
  output logic [7:0]        poll_match,
  input  logic              poll_done,
  input  logic              poll_err,
  output logic              done,
  output logic              err
);
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remaining;
  logic [LEN_W-1:0]  chunk;
  logic              last;

  fps_chunk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
    .cur_addr (cur_addr),
    .remaining(remaining),
    .chunk    (chunk),
    .last     (last)
  );

  fps_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .cmd_quad  (cmd_quad),
    .cmd_dummy (cmd_dummy),
    .cmd_done  (cmd_done),
    .cmd_err   (cmd_err),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_data   (wr_data),
    .poll_valid(poll_valid),
    .poll_ready(poll_ready),
    .poll_mask (poll_mask),
    .poll_match(poll_match),
    .poll_done (poll_done),
    .poll_err  (poll_err),
    .done      (done),
    .err       (err),
    .cur_addr  (cur_addr),
    .remaining (remaining),
    .chunk     (chunk),
    .last      (last)
  );

endmodule

// File: tb/flash_prog_splitter_tb.sv
`timescale 1ns/1ps
module flash_prog_splitter_tb;
  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;
  localparam int PAGE   = 256;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              s_valid, s_ready;
  logic [7:0]        s_data;
  logic              cmd_valid, cmd_ready;
  logic [1:0]        cmd_op;
  logic [ADDR_W-1:0] cmd_addr;
  logic [LEN_W-1:0]  cmd_len;
  logic              cmd_quad;
  logic [3:0]        cmd_dummy;
  logic              cmd_done, cmd_err;
  logic              wr_valid, wr_ready;
  logic [7:0]        wr_data;
  logic              poll_valid, poll_ready;
  logic [7:0]        poll_mask, poll_match;
  logic              poll_done, poll_err;
  logic              done, err;

  flash_prog_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_quad(cmd_quad), .cmd_dummy(cmd_dummy),
    .cmd_done(cmd_done), .cmd_err(cmd_err),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .poll_valid(poll_valid), .poll_ready(poll_ready), .poll_mask(poll_mask),
    .poll_match(poll_match), .poll_done(poll_done), .poll_err(poll_err),
    .done(done), .err(err)
  );

  // kind: 0 write enable, 1 program, 2 latch poll, 3 busy poll
  typedef struct packed {
    logic [1:0]        kind;
    logic [ADDR_W-1:0] addr;
    logic [LEN_W-1:0]  len;
  } item_t;

  item_t expq[$];
  int    checks = 0;
  int    fails  = 0;
  int    inj    = 0;
  int    beats  = 0;
  logic [7:0] exp_byte = 8'd0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input int addr, input int len);
    item_t it;
    it.kind = 2'(kind);
    it.addr = ADDR_W'(addr);
    it.len  = LEN_W'(len);
    expq.push_back(it);
  endtask

  // monitor: pops expected items as the design produces traffic
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid && cmd_ready) begin
        int k;
        k = (cmd_op == 2'd2) ? 1 : 0;
        if (expq.size() == 0) chk(0, "R7", "unexpected command", k, -1);
        else begin
          item_t e;
          e = expq.pop_front();
          chk(k == int'(e.kind), "R3", "command kind", k, e.kind);
          if (k == 1) begin
            chk(cmd_addr == e.addr, "R2", "program address", cmd_addr, e.addr);
            chk(cmd_len == e.len, "R1", "program length", cmd_len, e.len);
            chk(cmd_quad == 1'b1 && cmd_dummy == 4'd0, "R4", "quad/dummy",
                {cmd_quad, cmd_dummy}, 5'h10);
          end else begin
            chk(cmd_op == 2'd1, "R3", "write-enable opcode", cmd_op, 1);
          end
        end
      end
      if (rst_n && poll_valid && poll_ready) begin
        int k;
        k = (poll_mask == 8'h02) ? 2 : 3;
        if (expq.size() == 0) chk(0, "R7", "unexpected poll", k, -1);
        else begin
          item_t e;
          e = expq.pop_front();
          chk(k == int'(e.kind), "R5", "poll kind", k, e.kind);
          if (e.kind == 2'd2)
            chk(poll_mask == 8'h02 && poll_match == 8'h02, "R3", "latch poll mask/match",
                {poll_mask, poll_match}, 16'h0202);
          else
            chk(poll_mask == 8'h01 && poll_match == 8'h00, "R5", "busy poll mask/match",
                {poll_mask, poll_match}, 16'h0100);
        end
      end
      if (rst_n && wr_valid && wr_ready) begin
        chk(wr_data == exp_byte, "R6", "byte order", wr_data, exp_byte);
        exp_byte = exp_byte + 8'd1;
        beats++;
      end
    end
  end

  // byte source: advances after each accepted byte
  initial begin
    s_data = 8'd0;
    forever begin
      bit tk;
      @(negedge clk);
      tk = s_valid && s_ready;
      @(posedge clk);
      #1;
      if (tk) s_data = s_data + 8'd1;
    end
  end

  // command sequencer model
  initial begin
    cmd_done = 1'b0;
    cmd_err  = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid && cmd_ready) begin
        bit e;
        e = 1'b0;
        if (cmd_op == 2'd2) begin
          int n;
          int l;
          n = 0;
          l = int'(cmd_len);
          e = (inj == 2);
          while (n < l) begin
            @(negedge clk);
            if (wr_valid && wr_ready) n++;
          end
        end
        @(negedge clk);
        cmd_err  = e;
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        cmd_err  = 1'b0;
      end
    end
  end

  // status poller model
  initial begin
    poll_done = 1'b0;
    poll_err  = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && poll_valid && poll_ready) begin
        bit e;
        e = (poll_mask == 8'h02) ? (inj == 1) : (inj == 3);
        @(negedge clk);
        @(negedge clk);
        poll_err  = e;
        poll_done = 1'b1;
        @(negedge clk);
        poll_done = 1'b0;
        poll_err  = 1'b0;
      end
    end
  end

  // driver: builds the expected sequence, then launches the request
  // mode: 0 clean, 1 fail latch poll, 2 fail program, 3 fail busy poll
  task automatic run_req(input int addr, input int len, input int mode);
    int cur, last_a, csz, nbytes, b0, cyc;
    bit stop;
    inj    = mode;
    cur    = addr;
    last_a = addr + len;
    nbytes = 0;
    stop   = 1'b0;
    csz    = PAGE - (addr % PAGE);
    if (csz > len) csz = len;
    while (cur < last_a && !stop) begin
      push(0, 0, 0);
      push(2, 0, 0);
      if (mode == 1) stop = 1'b1;
      else begin
        push(1, cur, csz);
        nbytes += csz;
        if (mode == 2) stop = 1'b1;
        else begin
          push(3, 0, 0);
          if (mode == 3) stop = 1'b1;
        end
      end
      cur += csz;
      csz = ((cur + PAGE) > last_a) ? (last_a - cur) : PAGE;
    end
    b0 = beats;
    @(negedge clk);
    req_addr  = ADDR_W'(addr);
    req_len   = LEN_W'(len);
    req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1 && err == 1'b0, "R8", "zero-length done next cycle", done, 1);
    end else begin
      cyc = 0;
      while (!(done || err) && cyc < 5000) begin
        @(negedge clk);
        cyc++;
      end
      if (mode == 0)
        chk(done && !err, "R10", "completion pulse", {done, err}, 2'b10);
      else
        chk(err && !done, "R7", "abort pulse", {done, err}, 2'b01);
    end
    repeat (8) @(negedge clk);
    chk(expq.size() == 0, (mode == 0) ? "R2" : "R7", "sequence finished", expq.size(), 0);
    chk(beats - b0 == nbytes, "R6", "bytes forwarded", beats - b0, nbytes);
    chk(req_ready == 1'b1, "R7", "back to idle", req_ready, 1);
    expq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_addr   = '0;
    req_len    = '0;
    s_valid    = 1'b1;
    cmd_ready  = 1'b1;
    wr_ready   = 1'b1;
    poll_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !cmd_valid && !poll_valid && !wr_valid && !done && !err,
        "R9", "in reset", {req_ready, cmd_valid, poll_valid, wr_valid, done, err}, 6'b100000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !cmd_valid && !poll_valid && !wr_valid && !done && !err,
        "R9", "after reset", {req_ready, cmd_valid, poll_valid, wr_valid, done, err}, 6'b100000);

    run_req(32'h000100, 256, 0);   // R1 aligned full page
    run_req(32'h0000F0, 48, 0);    // R1 cut, R2 remainder
    run_req(32'h000205, 10, 0);    // R1 cap by size
    run_req(32'h0003C0, 600, 0);   // R2 multi-page
    run_req(32'h000400, 40, 0);    // R1 aligned, shorter than page
    run_req(32'h000080, 0, 0);     // R8 zero length
    run_req(32'h000010, 4, 1);     // R7 latch poll error
    run_req(32'h0000FC, 8, 2);     // R7 program error
    run_req(32'h0001FE, 6, 3);     // R7 busy poll error
    run_req(32'h000700, 300, 0);   // R5 recovery after aborts

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule